// File: doc/BRIEF.md
# Paged Virtual Memory Management Unit

This block maps a 16-bit virtual address onto a physical address of 18 or 22 bits. It holds a page set for each of three processor modes (kernel, supervisor, user). Each mode has one set for instruction fetches and one for data accesses, and each set has eight pages. Every page has an address register, which gives the page base in 64-byte units, and a descriptor. The descriptor carries an access code, a length and a direction of growth.

Each request is checked against its page's access code, against the installed memory size and against the page length. A request that fails is aborted with a trap vector. The first failure is recorded in a status register, which then holds its value until software clears it. The register file and the two control registers are read and written through a simple register port, which also supports byte writes.

The translated address, the abort flag and the vector appear one clock cycle after a request is presented.

Top module: `paged_mmu`

## Requirements
- R1: After reset, every page address register, every descriptor, the status register and the control register read as zero. No translation result is valid.
- R2: While status bit 0 is clear, a request returns the virtual address zero-extended, with no abort. A result is valid exactly one cycle after each request.
- R3: While status bit 0 is set, the physical address is computed in two steps. First, virtual bits 15:13 select the page. Second, the page's address register times 64 is added to virtual bits 12:0. When control bit 4 is clear, physical bits 21:18 are forced to zero.
- R4: A data request uses the data set only if its mode's enable bit in the control register is set: bit 2 for kernel (mode code 0), bit 1 for supervisor (code 1), bit 0 for user (code 3). Otherwise the instruction set is used.
- R5: A write aborts unless the descriptor access code (bits 2:0) is 6. A read aborts when the code is 0, 1, 3, 4 or 7. Both use vector octal 250. A read abort with code 0 or 4 sets status bit 15. Every other access abort sets status bit 13.
- R6: The length check compares virtual bits 12:6 with descriptor bits 14:8. With descriptor bit 3 clear, a larger block number aborts. With bit 3 set, a smaller block number aborts. A length abort uses vector octal 250 and sets status bit 14.
- R7: An address at or above the installed memory size aborts with vector octal 4 and sets status bit 15. The checks run in a fixed order: access code first, then the range check, then the length check.
- R8: A failure is recorded only while status bits 15:13 are all zero. Recording stores the page number in bits 3:1 and the mode code in bits 6:5, so later failures leave the status unchanged.
- R9: A translated write to an even virtual address sets bit 6 of the descriptor it used. Reads and odd-address writes leave that bit alone.
- R10: A register-port write to a descriptor clears bits 7:4. Byte enables merge only the selected byte of any register.
- R11: Status bits 11:10 always read as zero. The control register keeps only the bits of mask 0x37.
- R12: Register map. Port address bit 7 = 0 selects a page register: bits 6:5 give the mode code, bit 4 selects the data set, bit 3 selects the address register (1) or the descriptor (0), and bits 2:0 give the page. Mode code 2 in this field is ignored on write and reads as zero. Address 0x80 selects the status register and 0x81 the control register.
- R13: With no violation, the abort output stays low and the vector reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_wr | input | 1 | Register port write strobe |
| rb_addr | input | 8 | Register port address |
| rb_wdata | input | 16 | Register port write data |
| rb_be | input | 2 | Byte enables for the write |
| rb_rdata | output | 16 | Register port read data (combinational) |
| xl_req | input | 1 | Translation request |
| xl_vaddr | input | 16 | Virtual address |
| xl_mode | input | 2 | Mode code: 0 kernel, 1 supervisor, 3 user |
| xl_dspace | input | 1 | Request is a data access |
| xl_write | input | 1 | Request is a write |
| xl_valid | output | 1 | Result valid, one cycle after the request |
| xl_paddr | output | 22 | Physical address |
| xl_abort | output | 1 | Request aborted |
| xl_vector | output | 9 | Trap vector for the abort |

## Verification
Translation is first tried with mapping switched off, so any output that depends on the page set shows up as an error. It is then tried with a page base of all ones, once in the narrow and once in the wide setting. That single stimulus separates correct truncation from the range abort, and a second case with a bad access code as well proves that the access check wins. All eight access codes are swept for both reads and writes, which separates the non-resident class of failure from the read-only class. Length limits are tested at the boundary block and one block past it, for each direction of growth. A second failure in another mode and page shows whether the first record stays frozen.

// File: rtl/mmu_pkg.sv
`timescale 1ns/1ps
package mmu_pkg;
  localparam int VA_W        = 16;
  localparam int PA_W        = 22;
  localparam int PA_NARROW_W = 18;
  localparam int WORD_W      = 16;
  localparam int NPAGE       = 8;
  localparam int PG_W        = $clog2(NPAGE);
  localparam int OFF_W       = VA_W - PG_W;
  localparam int NSLOT       = 3;
  localparam int NBANK       = NSLOT * 2;
  localparam int BANK_W      = 3;
  localparam int NENT        = NBANK * NPAGE;
  localparam int PDR_W_BIT   = 6;
  localparam logic [WORD_W-1:0] CR3_KEEP = 16'h0037;
  localparam logic [8:0] VEC_PROT  = 9'o250;
  localparam logic [8:0] VEC_RANGE = 9'o004;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_USER = 2'd3
  } cpu_mode_e;

  // error class, ordered to match status bits 15:13
  typedef struct packed {
    logic nonres;
    logic length;
    logic rdonly;
  } err_t;

  typedef struct packed {
    logic       abort;
    err_t       err;
    logic [8:0] vector;
  } fault_t;

  function automatic logic [BANK_W-1:0] bank_of(input logic [1:0] mcode, input logic dsel);
    logic [1:0] slot;
    case (mcode)
      MODE_KERN: slot = 2'd0;
      MODE_SUPV: slot = 2'd1;
      default:   slot = 2'd2;
    endcase
    return {slot, dsel};
  endfunction

  function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] old_v,
                                                    input logic [WORD_W-1:0] new_v,
                                                    input logic [1:0]        be);
    logic [WORD_W-1:0] r;
    r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
    r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
    return r;
  endfunction
endpackage

// File: rtl/mmu_page_file.sv
`timescale 1ns/1ps
module mmu_page_file
  import mmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic              sw_is_par,
  input  logic [BANK_W-1:0] sw_bank,
  input  logic [PG_W-1:0]   sw_page,
  input  logic [1:0]        sw_be,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic              wset_en,
  input  logic [BANK_W-1:0] wset_bank,
  input  logic [PG_W-1:0]   wset_page,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [PG_W-1:0]   rd_page,
  output logic [WORD_W-1:0] rd_par,
  output logic [WORD_W-1:0] rd_pdr,
  input  logic [BANK_W-1:0] xl_bank,
  input  logic [PG_W-1:0]   xl_page,
  output logic [WORD_W-1:0] xl_par,
  output logic [WORD_W-1:0] xl_pdr
);
  logic [WORD_W-1:0] par_v [0:NENT-1];
  logic [WORD_W-1:0] pdr_v [0:NENT-1];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    localparam logic [BANK_W-1:0] BK = BANK_W'(e / NPAGE);
    localparam logic [PG_W-1:0]   PG = PG_W'(e % NPAGE);
    logic [WORD_W-1:0] par_r, par_n, pdr_r, pdr_n;
    logic sw_hit, w_hit;

    assign sw_hit = sw_we   && (sw_bank == BK)   && (sw_page == PG);
    assign w_hit  = wset_en && (wset_bank == BK) && (wset_page == PG);

    always_comb begin
      par_n = par_r;
      pdr_n = pdr_r;
      if (w_hit) pdr_n[PDR_W_BIT] = 1'b1;
      if (sw_hit && sw_is_par) par_n = merge_bytes(par_r, sw_wdata, sw_be);
      if (sw_hit && !sw_is_par) begin
        pdr_n      = merge_bytes(pdr_r, sw_wdata, sw_be);
        pdr_n[7:4] = 4'b0000;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        par_r <= '0;
        pdr_r <= '0;
      end else if (sw_hit || w_hit) begin
        par_r <= par_n;
        pdr_r <= pdr_n;
      end
    end

    assign par_v[e] = par_r;
    assign pdr_v[e] = pdr_r;
  end

  assign rd_par = par_v[{rd_bank, rd_page}];
  assign rd_pdr = pdr_v[{rd_bank, rd_page}];
  assign xl_par = par_v[{xl_bank, xl_page}];
  assign xl_pdr = pdr_v[{xl_bank, xl_page}];
endmodule

// File: rtl/mmu_xlate.sv
`timescale 1ns/1ps
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter longint unsigned PHYS_LIMIT = 64'h100000
) (
  input  logic              on,
  input  logic              wide,
  input  logic [2:0]        dsp_en,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [1:0]        mode,
  input  logic              dspace,
  input  logic              write,
  output logic [BANK_W-1:0] bank,
  output logic [PG_W-1:0]   page,
  input  logic [WORD_W-1:0] par,
  input  logic [WORD_W-1:0] pdr,
  output logic [PA_W-1:0]   paddr,
  output fault_t            fault
);
  localparam logic [PA_W:0] LIMIT_V = (PA_W+1)'(PHYS_LIMIT);

  logic            dsel;
  logic [PA_W-1:0] sum;
  logic [2:0]      ac;
  logic [6:0]      blk, len;
  logic            acc_bad, acc_nonres, range_bad, len_bad;
  logic            unused_pdr;

  assign unused_pdr = ^{pdr[15], pdr[7:4]};

  always_comb begin
    case (mode)
      MODE_KERN: dsel = dspace & dsp_en[2];
      MODE_SUPV: dsel = dspace & dsp_en[1];
      default:   dsel = dspace & dsp_en[0];
    endcase
  end

  assign bank = bank_of(mode, dsel);
  assign page = vaddr[VA_W-1:OFF_W];

  always_comb begin
    sum = PA_W'({par, 6'b000000}) + PA_W'(vaddr[OFF_W-1:0]);
    if (!wide) sum[PA_W-1:PA_NARROW_W] = '0;
  end

  assign ac         = pdr[2:0];
  assign blk        = vaddr[12:6];
  assign len        = pdr[14:8];
  assign acc_bad    = write ? (ac != 3'd6) : (ac inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd7});
  assign acc_nonres = !write && (ac inside {3'd0, 3'd4});
  assign range_bad  = ({1'b0, sum} >= LIMIT_V);
  assign len_bad    = pdr[3] ? (blk < len) : (blk > len);

  always_comb begin
    fault = '0;
    paddr = sum;
    if (!on) begin
      paddr = PA_W'(vaddr);
    end else if (acc_bad) begin
      fault.abort      = 1'b1;
      fault.err.nonres = acc_nonres;
      fault.err.rdonly = !acc_nonres;
      fault.vector     = VEC_PROT;
    end else if (range_bad) begin
      fault.abort      = 1'b1;
      fault.err.nonres = 1'b1;
      fault.vector     = VEC_RANGE;
    end else if (len_bad) begin
      fault.abort      = 1'b1;
      fault.err.length = 1'b1;
      fault.vector     = VEC_PROT;
    end
  end
endmodule

// File: rtl/mmu_ctrl_regs.sv
`timescale 1ns/1ps
module mmu_ctrl_regs
  import mmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_we,
  input  logic              cr3_we,
  input  logic [1:0]        be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rec_en,
  input  err_t              rec_err,
  input  logic [PG_W-1:0]   rec_page,
  input  logic [1:0]        rec_mode,
  output logic [WORD_W-1:0] stat_q,
  output logic [WORD_W-1:0] cr3_q
);
  logic [WORD_W-1:0] stat_n, cr3_n;
  logic              upd;

  always_comb begin
    stat_n = stat_q;
    cr3_n  = cr3_q;
    if (stat_we) begin
      stat_n        = merge_bytes(stat_q, wdata, be);
      stat_n[11:10] = 2'b00;
    end
    if (cr3_we) cr3_n = merge_bytes(cr3_q, wdata, be) & CR3_KEEP;
    if (rec_en && (stat_q[15:13] == 3'b000)) begin
      stat_n[15:13] = rec_err;
      stat_n[6:5]   = rec_mode;
      stat_n[3:1]   = rec_page;
    end
  end

  assign upd = stat_we | cr3_we | rec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      cr3_q  <= '0;
    end else if (upd) begin
      stat_q <= stat_n;
      cr3_q  <= cr3_n;
    end
  end
endmodule

// File: rtl/paged_mmu.sv
`timescale 1ns/1ps
module paged_mmu
  import mmu_pkg::*;
#(
  parameter longint unsigned PHYS_LIMIT = 64'h100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_wr,
  input  logic [7:0]        rb_addr,
  input  logic [WORD_W-1:0] rb_wdata,
  input  logic [1:0]        rb_be,
  output logic [WORD_W-1:0] rb_rdata,
  input  logic              xl_req,
  input  logic [VA_W-1:0]   xl_vaddr,
  input  logic [1:0]        xl_mode,
  input  logic              xl_dspace,
  input  logic              xl_write,
  output logic              xl_valid,
  output logic [PA_W-1:0]   xl_paddr,
  output logic              xl_abort,
  output logic [8:0]        xl_vector
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // register port decode
  logic              rb_is_ctl, rb_pg_ok;
  logic [BANK_W-1:0] rb_bank;
  logic [WORD_W-1:0] rd_par, rd_pdr, stat_q, cr3_q;

  assign rb_is_ctl = rb_addr[7];
  assign rb_pg_ok  = !rb_is_ctl && (rb_addr[6:5] != MODE_RSVD);
  assign rb_bank   = bank_of(rb_addr[6:5], rb_addr[4]);

  always_comb begin
    if (rb_is_ctl)     rb_rdata = rb_addr[0] ? cr3_q : stat_q;
    else if (rb_pg_ok) rb_rdata = rb_addr[3] ? rd_par : rd_pdr;
    else               rb_rdata = '0;
  end

  // translation path
  logic [BANK_W-1:0] xl_bank;
  logic [PG_W-1:0]   xl_page;
  logic [WORD_W-1:0] xl_par, xl_pdr;
  logic [PA_W-1:0]   paddr_c;
  fault_t            fault_c;
  logic              wset_en, rec_en;

  assign wset_en = xl_req && stat_q[0] && xl_write && !xl_vaddr[0];
  assign rec_en  = xl_req && fault_c.abort;

  mmu_page_file i_pages (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sw_we     (rb_wr && rb_pg_ok),
    .sw_is_par (rb_addr[3]),
    .sw_bank   (rb_bank),
    .sw_page   (rb_addr[2:0]),
    .sw_be     (rb_be),
    .sw_wdata  (rb_wdata),
    .wset_en   (wset_en),
    .wset_bank (xl_bank),
    .wset_page (xl_page),
    .rd_bank   (rb_bank),
    .rd_page   (rb_addr[2:0]),
    .rd_par    (rd_par),
    .rd_pdr    (rd_pdr),
    .xl_bank   (xl_bank),
    .xl_page   (xl_page),
    .xl_par    (xl_par),
    .xl_pdr    (xl_pdr)
  );

  mmu_xlate #(.PHYS_LIMIT(PHYS_LIMIT)) i_xlate (
    .on     (stat_q[0]),
    .wide   (cr3_q[4]),
    .dsp_en (cr3_q[2:0]),
    .vaddr  (xl_vaddr),
    .mode   (xl_mode),
    .dspace (xl_dspace),
    .write  (xl_write),
    .bank   (xl_bank),
    .page   (xl_page),
    .par    (xl_par),
    .pdr    (xl_pdr),
    .paddr  (paddr_c),
    .fault  (fault_c)
  );

  mmu_ctrl_regs i_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .stat_we  (rb_wr && rb_is_ctl && !rb_addr[0]),
    .cr3_we   (rb_wr && rb_is_ctl && rb_addr[0]),
    .be       (rb_be),
    .wdata    (rb_wdata),
    .rec_en   (rec_en),
    .rec_err  (fault_c.err),
    .rec_page (xl_page),
    .rec_mode (xl_mode),
    .stat_q   (stat_q),
    .cr3_q    (cr3_q)
  );

  // result register
  logic            valid_n, abort_n;
  logic [PA_W-1:0] paddr_n;
  logic [8:0]      vec_n;

  always_comb begin
    valid_n = xl_req;
    abort_n = xl_req & fault_c.abort;
    paddr_n = xl_req ? paddr_c : xl_paddr;
    vec_n   = xl_req ? fault_c.vector : xl_vector;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      xl_valid  <= 1'b0;
      xl_abort  <= 1'b0;
      xl_paddr  <= '0;
      xl_vector <= '0;
    end else begin
      xl_valid  <= valid_n;
      xl_abort  <= abort_n;
      xl_paddr  <= paddr_n;
      xl_vector <= vec_n;
    end
  end
endmodule

// File: rtl/mmu_checker.sv
`timescale 1ns/1ps
module mmu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rb_wr,
  input logic [7:0]  rb_addr,
  input logic        xl_req,
  input logic [15:0] xl_vaddr,
  input logic        xl_valid,
  input logic [21:0] xl_paddr,
  input logic        xl_abort,
  input logic [8:0]  xl_vector,
  input logic [15:0] stat_q,
  input logic [15:0] cr3_q
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_valid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> !xl_valid && !xl_abort); // R13

  AST_BYPASS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !stat_q[0]) |=> (!xl_abort && xl_paddr == {6'b0, $past(xl_vaddr)})); // R2

  AST_NARROW_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !cr3_q[4]) |=> (xl_paddr[21:18] == 4'b0000)); // R3

  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    xl_abort |-> (xl_vector == 9'o250 || xl_vector == 9'o004)); // R5

  AST_CLEAN_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !xl_abort) |-> (xl_vector == 9'd0)); // R13

  AST_ERR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q[15:13] != 3'b000) && !(rb_wr && rb_addr == 8'h80))
      |=> (stat_q[15:13] == $past(stat_q[15:13]))); // R8

  AST_STAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[11:10] == 2'b00); // R11

  AST_CR3_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cr3_q & ~16'h0037) == 16'h0000); // R11
endmodule

bind paged_mmu mmu_checker i_mmu_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rb_wr     (rb_wr),
  .rb_addr   (rb_addr),
  .xl_req    (xl_req),
  .xl_vaddr  (xl_vaddr),
  .xl_valid  (xl_valid),
  .xl_paddr  (xl_paddr),
  .xl_abort  (xl_abort),
  .xl_vector (xl_vector),
  .stat_q    (stat_q),
  .cr3_q     (cr3_q)
);

// File: tb/test_paged_mmu.sv
`timescale 1ns/1ps
module test_paged_mmu;
  localparam longint unsigned LIMIT = 64'h100000;
  localparam logic [7:0] A_STAT = 8'h80;
  localparam logic [7:0] A_CR3  = 8'h81;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rb_wr = 1'b0;
  logic [7:0]  rb_addr = 8'h00;
  logic [15:0] rb_wdata = 16'h0000;
  logic [1:0]  rb_be = 2'b00;
  logic [15:0] rb_rdata;
  logic        xl_req = 1'b0;
  logic [15:0] xl_vaddr = 16'h0000;
  logic [1:0]  xl_mode = 2'd0;
  logic        xl_dspace = 1'b0;
  logic        xl_write = 1'b0;
  logic        xl_valid;
  logic [21:0] xl_paddr;
  logic        xl_abort;
  logic [8:0]  xl_vector;

  always #2.5 clk = ~clk;

  paged_mmu #(.PHYS_LIMIT(LIMIT)) i_paged_mmu (
    .clk(clk), .rst_n(rst_n), .rb_wr(rb_wr), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .rb_be(rb_be), .rb_rdata(rb_rdata), .xl_req(xl_req), .xl_vaddr(xl_vaddr),
    .xl_mode(xl_mode), .xl_dspace(xl_dspace), .xl_write(xl_write), .xl_valid(xl_valid),
    .xl_paddr(xl_paddr), .xl_abort(xl_abort), .xl_vector(xl_vector)
  );

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic [21:0] pa;
    logic        ab;
    logic [8:0]  vec;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // shadow state, indexed by mode code, space, page
  logic [15:0] par_s [4][2][8];
  logic [15:0] pdr_s [4][2][8];
  logic [15:0] exp_stat = 16'h0000;
  logic [15:0] exp_cr3  = 16'h0000;

  function automatic logic [7:0] pg_a(input logic [1:0] m, input logic s, input logic k,
                                      input logic [2:0] p);
    return {1'b0, m, s, k, p};
  endfunction

  function automatic logic [15:0] mrg(input logic [15:0] o, input logic [15:0] n,
                                      input logic [1:0] be);
    return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rb_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    rb_wr = 1'b1; rb_addr = a; rb_wdata = d; rb_be = be;
    if (a[7]) begin
      if (a[0]) exp_cr3 = mrg(exp_cr3, d, be) & 16'h0037;
      else begin exp_stat = mrg(exp_stat, d, be); exp_stat[11:10] = 2'b00; end
    end else if (a[6:5] != 2'd2) begin
      if (a[3]) par_s[a[6:5]][a[4]][a[2:0]] = mrg(par_s[a[6:5]][a[4]][a[2:0]], d, be);
      else begin
        pdr_s[a[6:5]][a[4]][a[2:0]] = mrg(pdr_s[a[6:5]][a[4]][a[2:0]], d, be);
        pdr_s[a[6:5]][a[4]][a[2:0]][7:4] = 4'b0000;
      end
    end
    @(negedge clk);
    rb_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    rb_addr = a;
    #1;
    check(rb_rdata === e, tag, 32'(rb_rdata), 32'(e));
  endtask

  // expected result derived from the requirements
  task automatic model(input logic [15:0] va, input logic [1:0] m, input logic d,
                       input logic w, output logic [21:0] pa, output logic ab,
                       output logic [8:0] vec, output logic [2:0] err, output logic dsel);
    logic [15:0] par, pdr;
    logic [22:0] sum;
    int ac, blk, len;
    ab = 1'b0; vec = 9'd0; err = 3'b000;
    dsel = d && ((m == 2'd0 && exp_cr3[2]) || (m == 2'd1 && exp_cr3[1]) ||
                 (m == 2'd3 && exp_cr3[0]));
    pa = {6'b0, va};
    if (exp_stat[0]) begin
      par = par_s[m][dsel][va[15:13]];
      pdr = pdr_s[m][dsel][va[15:13]];
      sum = 23'(par) * 23'd64 + 23'(va[12:0]);
      if (!exp_cr3[4]) sum = sum & 23'h03FFFF;
      pa  = sum[21:0];
      ac  = int'(pdr[2:0]);
      blk = int'(va[12:6]);
      len = int'(pdr[14:8]);
      if (w && ac != 6) begin ab = 1; vec = 9'o250; err = 3'b001; end
      else if (!w && (ac == 0 || ac == 4)) begin ab = 1; vec = 9'o250; err = 3'b100; end
      else if (!w && (ac == 1 || ac == 3 || ac == 7)) begin ab = 1; vec = 9'o250; err = 3'b001; end
      else if (64'(sum) >= LIMIT) begin ab = 1; vec = 9'o004; err = 3'b100; end
      else if (pdr[3] ? (blk < len) : (blk > len)) begin ab = 1; vec = 9'o250; err = 3'b010; end
    end
  endtask

  task automatic xlate(input logic [15:0] va, input logic [1:0] m, input logic d,
                       input logic w, input string tag);
    exp_t it;
    logic [2:0] err;
    logic dsel;
    @(negedge clk);
    xl_req = 1'b1; xl_vaddr = va; xl_mode = m; xl_dspace = d; xl_write = w;
    model(va, m, d, w, it.pa, it.ab, it.vec, err, dsel);
    it.tag = tag;
    exp_q.push_back(it);
    if (exp_stat[0] && w && !va[0]) pdr_s[m][dsel][va[15:13]][6] = 1'b1;
    if (it.ab && exp_stat[15:13] == 3'b000) begin
      exp_stat[15:13] = err;
      exp_stat[6:5]   = m;
      exp_stat[3:1]   = va[15:13];
    end
    @(negedge clk);
    xl_req = 1'b0;
  endtask

  // monitor: compare each result with the front of the queue
  always @(negedge clk) begin
    if (rst_n && xl_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 result without request", 32'(xl_paddr), 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(xl_paddr === e.pa && xl_abort === e.ab && xl_vector === e.vec, e.tag,
              {1'b0, xl_abort, xl_vector, xl_paddr[20:0]},
              {1'b0, e.ab, e.vec, e.pa[20:0]});
        if (xl_paddr[21] !== e.pa[21]) check(1'b0, e.tag, 32'(xl_paddr), 32'(e.pa));
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 8; p++) begin
          par_s[m][s][p] = 16'h0000;
          pdr_s[m][s][p] = 16'h0000;
        end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(xl_valid === 1'b0, "R1 valid low after reset", 32'(xl_valid), 32'd0);
    chk_rd(A_STAT, 16'h0000, "R1 status reset");
    chk_rd(A_CR3, 16'h0000, "R1 control reset");
    chk_rd(pg_a(2'd3, 1'b1, 1'b1, 3'd7), 16'h0000, "R1 user data PAR reset");
    chk_rd(pg_a(2'd1, 1'b0, 1'b0, 3'd2), 16'h0000, "R1 supervisor PDR reset");

    // R2: mapping off
    xlate(16'hFFFE, 2'd0, 1'b0, 1'b0, "R2 bypass high address");
    xlate(16'h1235, 2'd3, 1'b1, 1'b1, "R2 bypass odd write");
    chk_rd(pg_a(2'd3, 1'b0, 1'b0, 3'd0), 16'h0000, "R9 no written bit while off");

    // kernel instruction set
    for (int p = 0; p < 8; p++) begin
      rb_write(pg_a(2'd0, 1'b0, 1'b1, 3'(p)), 16'h0200 + 16'(p) * 16'h0080, 2'b11);
      rb_write(pg_a(2'd0, 1'b0, 1'b0, 3'(p)), 16'h7F06, 2'b11);
    end
    rb_write(A_STAT, 16'h0001, 2'b11);

    // R3: mapping
    xlate(16'h2ABC, 2'd0, 1'b0, 1'b0, "R3 page 1 read");
    xlate(16'hFFFE, 2'd0, 1'b0, 1'b1, "R3 page 7 write");
    rb_write(pg_a(2'd0, 1'b0, 1'b1, 3'd6), 16'hFFFF, 2'b11);
    xlate(16'hC010, 2'd0, 1'b0, 1'b0, "R3 narrow truncation");
    // R7: wide mode exceeds memory
    rb_write(A_CR3, 16'h0010, 2'b11);
    xlate(16'hC010, 2'd0, 1'b0, 1'b0, "R7 range abort");
    chk_rd(A_STAT, 16'h800D, "R7 status non-resident page 6");
    rb_write(A_STAT, 16'h0001, 2'b11);
    rb_write(pg_a(2'd0, 1'b0, 1'b0, 3'd6), 16'h7F01, 2'b11);
    xlate(16'hC010, 2'd0, 1'b0, 1'b0, "R7 access check before range");
    chk_rd(A_STAT, 16'h200D, "R7 status read-only wins");
    rb_write(A_STAT, 16'h0001, 2'b11);
    rb_write(A_CR3, 16'h0000, 2'b11);
    rb_write(pg_a(2'd0, 1'b0, 1'b0, 3'd6), 16'h7F06, 2'b11);

    // R4: data-space selection
    rb_write(pg_a(2'd0, 1'b1, 1'b1, 3'd1), 16'h1000, 2'b11);
    rb_write(pg_a(2'd0, 1'b1, 1'b0, 3'd1), 16'h7F06, 2'b11);
    rb_write(pg_a(2'd3, 1'b0, 1'b1, 3'd0), 16'h0040, 2'b11);
    rb_write(pg_a(2'd3, 1'b0, 1'b0, 3'd0), 16'h7F06, 2'b11);
    rb_write(pg_a(2'd3, 1'b1, 1'b1, 3'd0), 16'h0080, 2'b11);
    rb_write(pg_a(2'd3, 1'b1, 1'b0, 3'd0), 16'h7F06, 2'b11);
    xlate(16'h2004, 2'd0, 1'b1, 1'b0, "R4 kernel data uses I set when disabled");
    rb_write(A_CR3, 16'h0004, 2'b11);
    xlate(16'h2004, 2'd0, 1'b1, 1'b0, "R4 kernel data uses D set");
    xlate(16'h0104, 2'd3, 1'b1, 1'b0, "R4 user data uses I set");
    rb_write(A_CR3, 16'h0005, 2'b11);
    xlate(16'h0104, 2'd3, 1'b1, 1'b0, "R4 user data uses D set");
    xlate(16'h0104, 2'd3, 1'b0, 1'b0, "R4 user instruction uses I set");
    rb_write(A_CR3, 16'h0000, 2'b11);

    // R5: access codes
    for (int c = 0; c < 8; c++) begin
      rb_write(pg_a(2'd0, 1'b0, 1'b0, 3'd2), 16'h7F00 | 16'(c), 2'b11);
      xlate(16'h4010, 2'd0, 1'b0, 1'b0, "R5 read access code");
      xlate(16'h4020, 2'd0, 1'b0, 1'b1, "R5 write access code");
      chk_rd(A_STAT, exp_stat, "R5 status after access");
      rb_write(A_STAT, 16'h0001, 2'b11);
    end

    // R6: length
    rb_write(pg_a(2'd0, 1'b0, 1'b0, 3'd3), 16'h0506, 2'b11);
    xlate(16'h6140, 2'd0, 1'b0, 1'b0, "R6 upward at limit");
    xlate(16'h6180, 2'd0, 1'b0, 1'b0, "R6 upward past limit");
    chk_rd(A_STAT, 16'h4007, "R6 length status");
    rb_write(A_STAT, 16'h0001, 2'b11);
    rb_write(pg_a(2'd0, 1'b0, 1'b0, 3'd3), 16'h050E, 2'b11);
    xlate(16'h6100, 2'd0, 1'b0, 1'b0, "R6 downward below limit");
    xlate(16'h6140, 2'd0, 1'b0, 1'b0, "R6 downward at limit");
    xlate(16'h7FC0, 2'd0, 1'b0, 1'b0, "R6 downward top block");
    rb_write(A_STAT, 16'h0001, 2'b11);

    // R8: first error frozen
    xlate(16'h6000, 2'd3, 1'b0, 1'b0, "R8 user non-resident");
    rb_write(pg_a(2'd0, 1'b0, 1'b0, 3'd2), 16'h7F01, 2'b11);
    xlate(16'h4000, 2'd0, 1'b0, 1'b0, "R8 second fault");
    chk_rd(A_STAT, 16'h8067, "R8 status keeps first fault");
    rb_write(A_STAT, 16'h0001, 2'b11);

    // R9: written bit
    xlate(16'h8002, 2'd0, 1'b0, 1'b1, "R9 even write");
    chk_rd(pg_a(2'd0, 1'b0, 1'b0, 3'd4), 16'h7F46, "R9 written bit set");
    xlate(16'hA003, 2'd0, 1'b0, 1'b1, "R9 odd write");
    xlate(16'hA004, 2'd0, 1'b0, 1'b0, "R9 read");
    chk_rd(pg_a(2'd0, 1'b0, 1'b0, 3'd5), 16'h7F06, "R9 written bit untouched");

    // R10: descriptor write masking, byte merge
    rb_write(pg_a(2'd0, 1'b0, 1'b0, 3'd5), 16'h7FFE, 2'b11);
    chk_rd(pg_a(2'd0, 1'b0, 1'b0, 3'd5), 16'h7F0E, "R10 descriptor bits 7:4 cleared");
    rb_write(pg_a(2'd0, 1'b0, 1'b1, 3'd5), 16'h1234, 2'b10);
    chk_rd(pg_a(2'd0, 1'b0, 1'b1, 3'd5), 16'h1280, "R10 high byte merge");
    rb_write(pg_a(2'd0, 1'b0, 1'b0, 3'd4), 16'h00F6, 2'b01);
    chk_rd(pg_a(2'd0, 1'b0, 1'b0, 3'd4), 16'h7F06, "R10 low byte merge clears 7:4");

    // R11: fixed bits
    rb_write(A_STAT, 16'hFFFF, 2'b11);
    chk_rd(A_STAT, 16'hF3FF, "R11 status gap bits");
    rb_write(A_CR3, 16'hFFFF, 2'b11);
    chk_rd(A_CR3, 16'h0037, "R11 control mask");
    rb_write(A_CR3, 16'h0000, 2'b11);
    rb_write(A_STAT, 16'h0000, 2'b11);

    // R12: reserved mode code region
    rb_write(pg_a(2'd2, 1'b0, 1'b1, 3'd0), 16'hBEEF, 2'b11);
    chk_rd(pg_a(2'd2, 1'b0, 1'b1, 3'd0), 16'h0000, "R12 reserved region reads zero");
    chk_rd(pg_a(2'd0, 1'b0, 1'b1, 3'd0), 16'h0200, "R12 kernel PAR unaffected");
    chk_rd(pg_a(2'd3, 1'b1, 1'b1, 3'd0), 16'h0080, "R12 user data PAR unaffected");

    // R13: clean result
    xlate(16'h0002, 2'd0, 1'b0, 1'b0, "R13 clean bypass");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results returned", 32'(exp_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule